// File: doc/BRIEF.md
# Rotating Extend-and-Accumulate Unit

This datapath carries out the twelve byte and halfword extension operations of a 32-bit integer core. The source operand is first rotated right by a whole number of bytes. A byte, a halfword or a pair of bytes is then taken from the rotated word and widened to 32 bits, with either sign or zero fill. The widened value can be added to a second operand. In pair mode, the two bytes each fill their own 16-bit lane, and the addition treats the lanes as two separate 16-bit sums.

Beside the datapath, a small guard marks register-index combinations as unpredictable. The guard also gates the register write with the condition-passed flag supplied by the core. The result, the write enable and the unpredictable flag pass through an output register, which a parameter can remove. Decoding of the instruction word, condition evaluation and the register file stay outside the block.

Top module: `rxa_unit`

## Requirements
- R1: The source word `rm_val` is rotated right by 8 × `rot` bits (`rot` = 0..3 gives 0, 8, 16 or 24) before any extraction. No carry is produced.
- R2: Operation code bits: `op[3]` = 1 for signed, `op[2]` = 1 for accumulate, `op[1:0]` = 00 byte, 01 halfword, 10 byte pair. Byte operations widen bits [7:0] of the rotated word to 32 bits, with sign fill when `op[3]` = 1 and zero fill otherwise.
- R3: Halfword operations widen bits [15:0] of the rotated word to 32 bits, with sign or zero fill chosen by `op[3]`.
- R4: Unsigned pair mode (`op[1:0]` = 10, `op[3]` = 0) produces the rotated word AND 0x00FF00FF.
- R5: Signed pair mode fills bits [15:8] from bit 7 and bits [31:24] from bit 23 of the rotated word.
- R6: Byte and halfword accumulate operations return `rn_val` plus the widened value, modulo 2^32.
- R7: Pair accumulate adds `rn_val` and the widened value as two separate 16-bit lanes. No carry passes from bit 15 into bit 16.
- R8: A destination index or `rm` index equal to 15 raises `unpred` and forces `wr_en` low.
- R9: In unsigned pair accumulate (`op` = 0110), an `rn` index of 15 also raises `unpred`. In other operations the `rn` index has no effect on `unpred`.
- R10: With `cond_ok` low, `wr_en` is low. `unpred` still reports the index check.
- R11: With `OUT_REG` = 1, outputs appear one clock after the inputs. A synchronous active-high reset clears `result`, `wr_en` and `unpred`.
- R12: The reserved code `op[1:0]` = 11 raises `unpred` and forces `wr_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code (signed, accumulate, kind) |
| rot | input | 2 | Rotation in whole bytes |
| rn_val | input | 32 | Accumulate operand |
| rm_val | input | 32 | Source operand |
| rd_idx | input | 4 | Destination register index |
| rm_idx | input | 4 | Source register index |
| rn_idx | input | 4 | Accumulate register index |
| cond_ok | input | 1 | Condition passed flag from the core |
| result | output | 32 | Extended (and accumulated) value |
| wr_en | output | 1 | Register write enable |
| unpred | output | 1 | Unpredictable index combination |

## Verification
Two functions can act in the same cycle: the condition gate and the unpredictable index guard. The bench provokes this by dropping `cond_ok` while the destination index is 15. It then expects `unpred` high together with `wr_en` low, which shows that the guard is still evaluated when the condition fails. In a second overlap, a lane sum overflows in pair accumulate. The bench judges this by setting the low lanes so that they wrap (0xFFFF + 0x0001 and 0x0080 + 0xFF80), and then checking that the upper lane receives no carry.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

    localparam int WORD_W   = 32;
    localparam int IDX_W    = 4;
    localparam int ROT_W    = 2;
    localparam int PC_INDEX = 15;

    typedef enum logic [1:0] {
        KIND_BYTE = 2'b00,
        KIND_HALF = 2'b01,
        KIND_PAIR = 2'b10,
        KIND_RSVD = 2'b11
    } ext_kind_e;

    // bit 3 signed, bit 2 accumulate, bits 1:0 kind
    typedef struct packed {
        logic      sgn;
        logic      acc;
        ext_kind_e kind;
    } op_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              wr;
        logic              unp;
    } out_t;

    function automatic op_t decode_op(input logic [3:0] code);
        op_t o;
        o.sgn  = code[3];
        o.acc  = code[2];
        o.kind = ext_kind_e'(code[1:0]);
        return o;
    endfunction

    function automatic logic is_pc(input logic [IDX_W-1:0] idx);
        return idx == IDX_W'(PC_INDEX);
    endfunction

endpackage

// File: rtl/rxa_rotator.sv
module rxa_rotator #(
    parameter int XLEN  = rxa_pkg::WORD_W,
    parameter int ROT_W = rxa_pkg::ROT_W
) (
    input  logic [XLEN-1:0]  src_i,
    input  logic [ROT_W-1:0] rot_i,
    output logic [XLEN-1:0]  dst_o
);
    localparam int NROT = 1 << ROT_W;
    localparam int STEP = XLEN / NROT;

    logic [XLEN-1:0] cand [NROT];

    for (genvar k = 0; k < NROT; k++) begin : g_rot
        if (k == 0) begin : g_none
            assign cand[k] = src_i;
        end else begin : g_turn
            assign cand[k] = {src_i[k*STEP-1:0], src_i[XLEN-1:k*STEP]};
        end
    end

    assign dst_o = cand[rot_i];
endmodule

// File: rtl/rxa_extender.sv
module rxa_extender
    import rxa_pkg::*;
#(
    parameter int XLEN = WORD_W
) (
    input  logic [XLEN-1:0] word_i,
    input  ext_kind_e       kind_i,
    input  logic            sgn_i,
    output logic [XLEN-1:0] ext_o
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = XLEN / 2;
    localparam int NLANE  = XLEN / HALF_W;

    logic [XLEN-1:0] pair_w;
    logic [XLEN-1:0] byte_w;
    logic [XLEN-1:0] half_w;
    logic            unused_top;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [BYTE_W-1:0] b;
        assign b = word_i[l*HALF_W +: BYTE_W];
        assign pair_w[l*HALF_W +: HALF_W] =
            {{(HALF_W-BYTE_W){sgn_i & b[BYTE_W-1]}}, b};
    end

    assign byte_w = {{(XLEN-BYTE_W){sgn_i & word_i[BYTE_W-1]}}, word_i[BYTE_W-1:0]};
    assign half_w = {{(XLEN-HALF_W){sgn_i & word_i[HALF_W-1]}}, word_i[HALF_W-1:0]};
    assign unused_top = ^word_i[XLEN-1 -: BYTE_W];

    always_comb begin
        unique case (kind_i)
            KIND_BYTE: ext_o = byte_w;
            KIND_HALF: ext_o = half_w;
            KIND_PAIR: ext_o = pair_w;
            default:   ext_o = '0;
        endcase
    end
endmodule

// File: rtl/rxa_accum.sv
module rxa_accum #(
    parameter int XLEN = rxa_pkg::WORD_W
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] ext_i,
    input  logic            acc_i,
    input  logic            split_i,
    output logic [XLEN-1:0] sum_o
);
    localparam int LANE_W = XLEN / 2;
    localparam int NLANE  = XLEN / LANE_W;

    logic [XLEN-1:0] lane_sum;
    logic [XLEN-1:0] full_sum;

    assign full_sum = base_i + ext_i;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign lane_sum[l*LANE_W +: LANE_W] =
            base_i[l*LANE_W +: LANE_W] + ext_i[l*LANE_W +: LANE_W];
    end

    always_comb begin
        if (!acc_i)
            sum_o = ext_i;
        else if (split_i)
            sum_o = lane_sum;
        else
            sum_o = full_sum;
    end
endmodule

// File: rtl/rxa_guard.sv
module rxa_guard
    import rxa_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  op_t           op_i,
    input  logic [IW-1:0] rd_i,
    input  logic [IW-1:0] rm_i,
    input  logic [IW-1:0] rn_i,
    input  logic          cond_i,
    output logic          unp_o,
    output logic          wr_o
);
    logic base_bad;
    logic rn_bad;
    logic rsvd;

    assign base_bad = is_pc(rd_i) || is_pc(rm_i);
    assign rn_bad   = (op_i.kind == KIND_PAIR) && op_i.acc && !op_i.sgn && is_pc(rn_i);
    assign rsvd     = (op_i.kind == KIND_RSVD);

    assign unp_o = base_bad || rn_bad || rsvd;
    assign wr_o  = cond_i && !unp_o;
endmodule

// File: rtl/rxa_unit.sv
module rxa_unit
    import rxa_pkg::*;
#(
    parameter int XLEN    = WORD_W,
    parameter int IW      = IDX_W,
    parameter int RW      = ROT_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      op,
    input  logic [RW-1:0]   rot,
    input  logic [XLEN-1:0] rn_val,
    input  logic [XLEN-1:0] rm_val,
    input  logic [IW-1:0]   rd_idx,
    input  logic [IW-1:0]   rm_idx,
    input  logic [IW-1:0]   rn_idx,
    input  logic            cond_ok,
    output logic [XLEN-1:0] result,
    output logic            wr_en,
    output logic            unpred
);
    op_t             dec;
    logic [XLEN-1:0] rotated;
    logic [XLEN-1:0] widened;
    logic [XLEN-1:0] summed;
    logic            unp_c;
    logic            wr_c;

    assign dec = decode_op(op);

    rxa_rotator #(.XLEN(XLEN), .ROT_W(RW)) rot_i (
        .src_i (rm_val),
        .rot_i (rot),
        .dst_o (rotated)
    );

    rxa_extender #(.XLEN(XLEN)) ext_i (
        .word_i (rotated),
        .kind_i (dec.kind),
        .sgn_i  (dec.sgn),
        .ext_o  (widened)
    );

    rxa_accum #(.XLEN(XLEN)) acc_i (
        .base_i  (rn_val),
        .ext_i   (widened),
        .acc_i   (dec.acc),
        .split_i (dec.kind == KIND_PAIR),
        .sum_o   (summed)
    );

    rxa_guard #(.IW(IW)) grd_i (
        .op_i   (dec),
        .rd_i   (rd_idx),
        .rm_i   (rm_idx),
        .rn_i   (rn_idx),
        .cond_i (cond_ok),
        .unp_o  (unp_c),
        .wr_o   (wr_c)
    );

    if (OUT_REG) begin : g_reg
        logic [XLEN-1:0] res_q;
        logic            wr_q;
        logic            unp_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                wr_q  <= 1'b0;
                unp_q <= 1'b0;
            end else begin
                res_q <= summed;
                wr_q  <= wr_c;
                unp_q <= unp_c;
            end
        end
        assign result = res_q;
        assign wr_en  = wr_q;
        assign unpred = unp_q;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign result = summed;
        assign wr_en  = wr_c;
        assign unpred = unp_c;
    end
endmodule

// File: rtl/rxa_unit_chk.sv
module rxa_unit_chk #(
    parameter int XLEN    = 32,
    parameter int IW      = 4,
    parameter bit OUT_REG = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic [3:0]      op,
    input logic [IW-1:0]   rd_idx,
    input logic [IW-1:0]   rm_idx,
    input logic [IW-1:0]   rn_idx,
    input logic            cond_ok,
    input logic [XLEN-1:0] result,
    input logic            wr_en,
    input logic            unpred
);
    localparam logic [IW-1:0] PC = IW'(15);

    logic [3:0]    s_op;
    logic [IW-1:0] s_rd, s_rm, s_rn;
    logic          s_cond;
    logic          s_v;
    logic          rst_q;

    if (OUT_REG) begin : g_d
        logic [3:0]    op_q;
        logic [IW-1:0] rd_q, rm_q, rn_q;
        logic          cond_q, v_q;
        always_ff @(posedge clk) begin
            op_q   <= op;
            rd_q   <= rd_idx;
            rm_q   <= rm_idx;
            rn_q   <= rn_idx;
            cond_q <= cond_ok;
            v_q    <= !rst;
        end
        assign s_op = op_q; assign s_rd = rd_q; assign s_rm = rm_q;
        assign s_rn = rn_q; assign s_cond = cond_q; assign s_v = v_q;
    end else begin : g_c
        assign s_op = op; assign s_rd = rd_idx; assign s_rm = rm_idx;
        assign s_rn = rn_idx; assign s_cond = cond_ok; assign s_v = 1'b1;
    end

    always_ff @(posedge clk) rst_q <= rst;

    // R11: outputs cleared after a reset edge
    always @(negedge clk) begin
        if (OUT_REG && rst_q === 1'b1)
            a_r11_reset_clear: assert (!wr_en && !unpred && result == '0);
    end

    a_r8_pc_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (s_v && (s_rd == PC || s_rm == PC)) |-> (unpred && !wr_en));

    a_r9_rn_pc_pair: assert property (@(posedge clk) disable iff (rst)
        (s_v && s_op == 4'b0110 && s_rn == PC) |-> unpred);

    a_r10_cond_low_no_write: assert property (@(posedge clk) disable iff (rst)
        (s_v && !s_cond) |-> !wr_en);

    a_r2_zero_byte: assert property (@(posedge clk) disable iff (rst)
        (s_v && s_op == 4'b0000) |-> (result[XLEN-1:8] == '0));

    a_r3_zero_half: assert property (@(posedge clk) disable iff (rst)
        (s_v && s_op == 4'b0001) |-> (result[XLEN-1:16] == '0));

    a_r4_pair_mask: assert property (@(posedge clk) disable iff (rst)
        (s_v && s_op == 4'b0010) |-> ((result & 32'hFF00FF00) == '0));

    a_r12_reserved: assert property (@(posedge clk) disable iff (rst)
        (s_v && s_op[1:0] == 2'b11) |-> (unpred && !wr_en));
endmodule

bind rxa_unit rxa_unit_chk #(.XLEN(XLEN), .IW(IW), .OUT_REG(OUT_REG)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .rd_idx  (rd_idx),
    .rm_idx  (rm_idx),
    .rn_idx  (rn_idx),
    .cond_ok (cond_ok),
    .result  (result),
    .wr_en   (wr_en),
    .unpred  (unpred)
);

// File: tb/rxa_unit_tb_top.sv
module rxa_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op;
    logic [1:0]  rot;
    logic [31:0] rn_val, rm_val;
    logic [3:0]  rd_idx, rm_idx, rn_idx;
    logic        cond_ok;
    logic [31:0] result;
    logic        wr_en, unpred;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    rxa_unit dut_i (
        .clk(clk), .rst(rst), .op(op), .rot(rot), .rn_val(rn_val), .rm_val(rm_val),
        .rd_idx(rd_idx), .rm_idx(rm_idx), .rn_idx(rn_idx), .cond_ok(cond_ok),
        .result(result), .wr_en(wr_en), .unpred(unpred)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  rot;
        logic [31:0] rn;
        logic [31:0] rm;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{4'b1000, 2'd0, 32'h0,        32'h80F17F82, 32'hFFFFFF82}, // R2 signed byte
        '{4'b0000, 2'd1, 32'h0,        32'h80F17F82, 32'h0000007F}, // R1 R2 ror 8
        '{4'b1001, 2'd2, 32'h0,        32'h80F17F82, 32'hFFFF80F1}, // R3 signed half ror 16
        '{4'b0001, 2'd3, 32'h0,        32'h80F17F82, 32'h00008280}, // R3 ror 24
        '{4'b1010, 2'd0, 32'h0,        32'h80F17F82, 32'hFFF1FF82}, // R5
        '{4'b0010, 2'd1, 32'h0,        32'h80F17F82, 32'h0080007F}, // R4
        '{4'b1100, 2'd1, 32'h00010002, 32'h80F17F82, 32'h00010081}, // R6
        '{4'b0100, 2'd0, 32'hFFFFFFFF, 32'h80F17F82, 32'h00000081}, // R6 wrap
        '{4'b1101, 2'd0, 32'h00010002, 32'h80F17F82, 32'h00017F84}, // R6 half
        '{4'b0101, 2'd2, 32'hFFFF0000, 32'h80F17F82, 32'hFFFF80F1}, // R6 half
        '{4'b0110, 2'd0, 32'h0000FFFF, 32'h80F17F82, 32'h00F10081}, // R7
        '{4'b1110, 2'd2, 32'h00010002, 32'h80F17F82, 32'hFF83FFF3}, // R7 signed
        '{4'b0110, 2'd0, 32'h0001FFFF, 32'h00000001, 32'h00010000}, // R7 lane wrap
        '{4'b1110, 2'd0, 32'h00800080, 32'h00800080, 32'h00000000}, // R7 no carry
        '{4'b0001, 2'd1, 32'h0,        32'h12345678, 32'h00003456}  // R1
    };

    function automatic logic [31:0] model(logic [3:0] o, logic [1:0] r,
                                          logic [31:0] n, logic [31:0] m);
        logic [63:0] dbl;
        logic [31:0] w, e;
        logic [15:0] lo, hi;
        dbl = {m, m};
        w   = dbl[r*8 +: 32];
        lo  = {{8{o[3] & w[7]}},  w[7:0]};
        hi  = {{8{o[3] & w[23]}}, w[23:16]};
        case (o[1:0])
            2'b00:   e = o[3] ? {{24{w[7]}}, w[7:0]}   : {24'h0, w[7:0]};
            2'b01:   e = o[3] ? {{16{w[15]}}, w[15:0]} : {16'h0, w[15:0]};
            default: e = {hi, lo};
        endcase
        if (!o[2]) return e;
        if (o[1:0] == 2'b10) return {n[31:16] + hi, n[15:0] + lo};
        return n + e;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] o, logic [1:0] r, logic [31:0] n, logic [31:0] m,
                         logic [3:0] d, logic [3:0] mi, logic [3:0] ni, logic c);
        op = o; rot = r; rn_val = n; rm_val = m;
        rd_idx = d; rm_idx = mi; rn_idx = ni; cond_ok = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        op = 4'b0000; rot = 2'd0; rn_val = '0; rm_val = 32'hA5A5A5A5;
        rd_idx = 4'd1; rm_idx = 4'd2; rn_idx = 4'd3; cond_ok = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state, even with a valid write pending
        chk("R11 reset wr_en", {31'h0, wr_en}, 32'h0);
        chk("R11 reset unpred", {31'h0, unpred}, 32'h0);
        chk("R11 reset result", result, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].rot, VECS[i].rn, VECS[i].rm, 4'd1, 4'd2, 4'd3, 1'b1);
            chk($sformatf("vector %0d op=%b", i, VECS[i].op), result, VECS[i].exp);
            chk("R8 wr_en on clean write", {31'h0, wr_en}, 32'h1);
        end

        // R1: every operation at every rotation over random operands
        for (int o = 0; o < 16; o++) begin
            if (o[1:0] == 2'b11) continue;
            for (int r = 0; r < 4; r++) begin
                for (int k = 0; k < 12; k++) begin
                    logic [31:0] n, m;
                    n = $urandom; m = $urandom;
                    apply(4'(o), 2'(r), n, m, 4'd4, 4'd5, 4'd6, 1'b1);
                    chk($sformatf("R1 sweep op=%b rot=%0d", 4'(o), r), result,
                        model(4'(o), 2'(r), n, m));
                end
            end
        end

        // R8: destination index 15
        apply(4'b0000, 2'd0, 0, 32'h11, 4'd15, 4'd2, 4'd3, 1'b1);
        chk("R8 rd=15 unpred", {31'h0, unpred}, 32'h1);
        chk("R8 rd=15 wr_en", {31'h0, wr_en}, 32'h0);
        // R8: source index 15
        apply(4'b1001, 2'd0, 0, 32'h11, 4'd1, 4'd15, 4'd3, 1'b1);
        chk("R8 rm=15 unpred", {31'h0, unpred}, 32'h1);
        chk("R8 rm=15 wr_en", {31'h0, wr_en}, 32'h0);
        // R9: rn=15 on unsigned pair accumulate
        apply(4'b0110, 2'd0, 0, 32'h11, 4'd1, 4'd2, 4'd15, 1'b1);
        chk("R9 udual rn=15 unpred", {31'h0, unpred}, 32'h1);
        chk("R9 udual rn=15 wr_en", {31'h0, wr_en}, 32'h0);
        // R9: rn=15 has no effect on signed pair accumulate or byte accumulate
        apply(4'b1110, 2'd0, 0, 32'h11, 4'd1, 4'd2, 4'd15, 1'b1);
        chk("R9 sdual rn=15 unpred", {31'h0, unpred}, 32'h0);
        chk("R9 sdual rn=15 wr_en", {31'h0, wr_en}, 32'h1);
        apply(4'b0100, 2'd0, 0, 32'h11, 4'd1, 4'd2, 4'd15, 1'b1);
        chk("R9 byte acc rn=15 unpred", {31'h0, unpred}, 32'h0);
        // R10: condition failed
        apply(4'b0001, 2'd0, 0, 32'h1234, 4'd1, 4'd2, 4'd3, 1'b0);
        chk("R10 cond low wr_en", {31'h0, wr_en}, 32'h0);
        chk("R10 cond low unpred", {31'h0, unpred}, 32'h0);
        // R10 with R8 in the same cycle
        apply(4'b0001, 2'd0, 0, 32'h1234, 4'd15, 4'd2, 4'd3, 1'b0);
        chk("R10 cond low rd=15 unpred", {31'h0, unpred}, 32'h1);
        chk("R10 cond low rd=15 wr_en", {31'h0, wr_en}, 32'h0);
        // R12: reserved kind
        apply(4'b0011, 2'd0, 0, 32'h1234, 4'd1, 4'd2, 4'd3, 1'b1);
        chk("R12 reserved unpred", {31'h0, unpred}, 32'h1);
        chk("R12 reserved wr_en", {31'h0, wr_en}, 32'h0);
        // R11: one-cycle latency, output holds old value before the edge
        apply(4'b0000, 2'd0, 0, 32'h000000AA, 4'd1, 4'd2, 4'd3, 1'b1);
        rm_val = 32'h00000055;
        #1;
        chk("R11 latency hold", result, 32'h000000AA);
        @(posedge clk); @(negedge clk);
        chk("R11 latency update", result, 32'h00000055);
        // R11: reset in mid stream
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R11 midstream reset wr_en", {31'h0, wr_en}, 32'h0);
        chk("R11 midstream reset result", result, 32'h0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule